// File: doc/BRIEF.md
# One-Way ROM Ownership Multiplexer

This block sits in front of a single read port of a ROM and decides who may drive it. After reset an internal integrity checker owns the port, so it can walk the ROM contents before anything else reads them. A 4-bit multi-bit select from the control logic later hands the port to the system bus. Ownership moves once and never comes back. Address, request and returned read data are steered to whichever side currently owns the port.

The select is watched for two kinds of fault. The first is any value that is neither of the two legal codes. The second is any return to checker ownership after the bus has taken over. Each fault raises its own sticky fatal alert that only reset clears. While either alert is high, the bus is refused new reads and gets no read-valid, even for a read that was already in flight. The ROM answers one cycle after a request, and bus reads are pipelined, so N back-to-back reads complete in N+1 cycles.

Top module: `rom_owner_mux`

## Requirements
- R1: After reset the checker owns the port. romReq_o equals chkReq_i, romAddr_o equals chkAddr_i, busReady_o is low, both alerts are low, and both valid outputs are low.
- R2: When selBus_i equals 4'b0110 at a rising edge, the bus owns the port from that edge on. busReady_o goes high, romAddr_o follows busAddr_i, and romReq_o follows busReq_i.
- R3: The handover is permanent. Once the bus owns the port, no later select value returns romAddr_o to chkAddr_i. Checker requests after the handover produce no ROM request and no chkValid_o.
- R4: When selBus_i is sampled at a rising edge holding any value other than 4'b0110 or 4'b1001, alertInvalid_o is high from that edge until reset.
- R5: When selBus_i equals 4'b1001 at a rising edge after the handover, alertRevert_o is high from that edge until reset.
- R6: A bus read accepted at a rising edge (busReq_i and busReady_o both high) gives busValid_o high in the following cycle, with busData_o equal to romData_i. Reads accepted on N consecutive edges give N consecutive valid cycles.
- R7: A checker read accepted before the handover gives chkValid_o high in the following cycle, with chkData_o equal to romData_i.
- R8: While either alert is high, busReady_o and busValid_o stay low. A bus read accepted on the same edge that a fault is sampled never produces busValid_o.
- R9: busData_o is zero whenever busValid_o is low, and chkData_o is zero whenever chkValid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| selBus_i | input | 4 | Multi-bit owner select: 4'b0110 gives the port to the bus, 4'b1001 keeps it with the checker |
| chkReq_i | input | 1 | Checker read request |
| chkAddr_i | input | AddrWidth | Checker read address |
| chkValid_o | output | 1 | Checker read data valid |
| chkData_o | output | DataWidth | Checker read data |
| busReq_i | input | 1 | Bus read request |
| busAddr_i | input | AddrWidth | Bus read address |
| busReady_o | output | 1 | Bus request accepted this cycle if high |
| busValid_o | output | 1 | Bus read data valid |
| busData_o | output | DataWidth | Bus read data |
| romReq_o | output | 1 | ROM read strobe |
| romAddr_o | output | AddrWidth | ROM read address |
| romData_i | input | DataWidth | ROM read data, one cycle after romReq_o |
| alertInvalid_o | output | 1 | Sticky fatal alert: illegal select code seen |
| alertRevert_o | output | 1 | Sticky fatal alert: select returned to the checker after the handover |

## Verification
The assertions assume a ROM that answers exactly one cycle after each strobe and a select input that changes only between clock edges. They also assume that a bus request is not counted as accepted in the cycle where the select shows anything other than the bus-owner code. The stimulus drives every input on the falling edge. It models the ROM as a register fed from romAddr_o. It keeps legal select codes stable for whole cycles and injects each fault as a single cycle of one illegal or reverting code.

// File: rtl/rom_mux_pkg.sv
package rom_mux_pkg;

  localparam int unsigned SelWidth = 4;

  // Owner select codes: exactly one legal value per owner.
  localparam logic [SelWidth-1:0] SelBusOwns = 4'b0110;
  localparam logic [SelWidth-1:0] SelChkOwns = 4'b1001;

  // Strobes from control to datapath.
  typedef struct packed {
    logic busOwn;     // ownership has passed to the bus
    logic busAccept;  // bus read issued to ROM this cycle
    logic chkAccept;  // checker read issued to ROM this cycle
    logic fatal;      // any sticky fault is set
  } muxStrobe_t;

  function automatic logic selLegal(input logic [SelWidth-1:0] sel);
    return (sel == SelBusOwns) || (sel == SelChkOwns);
  endfunction

endpackage

// File: rtl/rom_mux_ctrl.sv
module rom_mux_ctrl
  import rom_mux_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SelWidth-1:0] selBus_i,
  input  logic                chkReq_i,
  input  logic                busReq_i,
  output muxStrobe_t          strobe_o,
  output logic                busReady_o,
  output logic                alertInvalid_o,
  output logic                alertRevert_o
);

  logic [SelWidth-1:0] selQ;
  logic ownedQ;
  logic invalidQ;
  logic revertQ;

  logic liveTrue;
  logic liveFalse;
  logic liveBad;
  logic heldBad;
  logic heldFalse;
  logic revertHit;
  logic fatal;

  // Decode the live select and its registered copy.
  always_comb begin
    liveTrue  = (selBus_i == SelBusOwns);
    liveFalse = (selBus_i == SelChkOwns);
    liveBad   = !selLegal(selBus_i);
    heldBad   = !selLegal(selQ);
    heldFalse = (selQ == SelChkOwns);
    revertHit = ownedQ && (liveFalse || heldFalse);
    fatal     = invalidQ || revertQ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      selQ     <= SelChkOwns;
      ownedQ   <= 1'b0;
      invalidQ <= 1'b0;
      revertQ  <= 1'b0;
    end else begin
      selQ     <= selBus_i;
      ownedQ   <= ownedQ || liveTrue;
      invalidQ <= invalidQ || liveBad || heldBad;
      revertQ  <= revertQ || revertHit;
    end
  end

  always_comb begin
    strobe_o.busOwn    = ownedQ;
    strobe_o.fatal     = fatal;
    strobe_o.busAccept = ownedQ && !fatal && busReq_i;
    strobe_o.chkAccept = !ownedQ && chkReq_i;
  end

  assign busReady_o     = ownedQ && !fatal;
  assign alertInvalid_o = invalidQ;
  assign alertRevert_o  = revertQ;

endmodule

// File: rtl/rom_mux_datapath.sv
module rom_mux_datapath
  import rom_mux_pkg::*;
#(
  parameter int unsigned AddrWidth = 8,
  parameter int unsigned DataWidth = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  muxStrobe_t           strobe_i,
  input  logic [AddrWidth-1:0] chkAddr_i,
  input  logic [AddrWidth-1:0] busAddr_i,
  input  logic [DataWidth-1:0] romData_i,
  output logic                 romReq_o,
  output logic [AddrWidth-1:0] romAddr_o,
  output logic                 busValid_o,
  output logic [DataWidth-1:0] busData_o,
  output logic                 chkValid_o,
  output logic [DataWidth-1:0] chkData_o
);

  logic busPendQ;
  logic chkPendQ;

  assign romReq_o  = strobe_i.busAccept || strobe_i.chkAccept;
  assign romAddr_o = strobe_i.busOwn ? busAddr_i : chkAddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busPendQ <= 1'b0;
      chkPendQ <= 1'b0;
    end else begin
      busPendQ <= strobe_i.busAccept;
      chkPendQ <= strobe_i.chkAccept;
    end
  end

  // A read in flight when a fault lands is dropped.
  assign busValid_o = busPendQ && !strobe_i.fatal;
  assign chkValid_o = chkPendQ;

  // Return data is zeroed per bit outside its valid cycle.
  for (genvar b = 0; b < DataWidth; b++) begin : g_dataGate
    assign busData_o[b] = busValid_o && romData_i[b];
    assign chkData_o[b] = chkValid_o && romData_i[b];
  end

endmodule

// File: rtl/rom_owner_mux.sv
module rom_owner_mux
  import rom_mux_pkg::*;
#(
  parameter int unsigned AddrWidth = 8,
  parameter int unsigned DataWidth = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SelWidth-1:0]  selBus_i,
  input  logic                 chkReq_i,
  input  logic [AddrWidth-1:0] chkAddr_i,
  output logic                 chkValid_o,
  output logic [DataWidth-1:0] chkData_o,
  input  logic                 busReq_i,
  input  logic [AddrWidth-1:0] busAddr_i,
  output logic                 busReady_o,
  output logic                 busValid_o,
  output logic [DataWidth-1:0] busData_o,
  output logic                 romReq_o,
  output logic [AddrWidth-1:0] romAddr_o,
  input  logic [DataWidth-1:0] romData_i,
  output logic                 alertInvalid_o,
  output logic                 alertRevert_o
);

  muxStrobe_t strobe;

  rom_mux_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .selBus_i       (selBus_i),
    .chkReq_i       (chkReq_i),
    .busReq_i       (busReq_i),
    .strobe_o       (strobe),
    .busReady_o     (busReady_o),
    .alertInvalid_o (alertInvalid_o),
    .alertRevert_o  (alertRevert_o)
  );

  rom_mux_datapath #(
    .AddrWidth (AddrWidth),
    .DataWidth (DataWidth)
  ) u_datapath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe),
    .chkAddr_i  (chkAddr_i),
    .busAddr_i  (busAddr_i),
    .romData_i  (romData_i),
    .romReq_o   (romReq_o),
    .romAddr_o  (romAddr_o),
    .busValid_o (busValid_o),
    .busData_o  (busData_o),
    .chkValid_o (chkValid_o),
    .chkData_o  (chkData_o)
  );

endmodule

// File: rtl/rom_mux_chk.sv
module rom_mux_chk
  import rom_mux_pkg::*;
#(
  parameter int unsigned AddrWidth = 8,
  parameter int unsigned DataWidth = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [SelWidth-1:0]  selBus_i,
  input logic                 busReq_i,
  input logic [AddrWidth-1:0] busAddr_i,
  input logic                 busReady_o,
  input logic                 busValid_o,
  input logic [DataWidth-1:0] busData_o,
  input logic                 chkValid_o,
  input logic [AddrWidth-1:0] romAddr_o,
  input logic                 alertInvalid_o,
  input logic                 alertRevert_o
);

  // R4
  illegal_sel_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !selLegal(selBus_i) |=> alertInvalid_o);

  // R4
  invalid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alertInvalid_o |=> alertInvalid_o);

  // R5
  revert_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busReady_o && selBus_i == SelChkOwns) |=> alertRevert_o);

  // R5
  revert_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alertRevert_o |=> alertRevert_o);

  // R8
  fault_gates_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alertInvalid_o || alertRevert_o) |-> (!busValid_o && !busReady_o));

  // R6
  bus_read_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busReq_i && busReady_o && selBus_i == SelBusOwns) |=> busValid_o);

  // R3
  owner_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busReady_o |=> (romAddr_o == busAddr_i) && !chkValid_o);

  // R9
  bus_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busValid_o |-> (busData_o == '0));

endmodule

bind rom_owner_mux rom_mux_chk #(
  .AddrWidth (AddrWidth),
  .DataWidth (DataWidth)
) chk_i (.*);

// File: tb/rom_owner_mux_tb.sv
module rom_owner_mux_tb_top;

  localparam int unsigned ClkPeriod = 10;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam logic [3:0] ST = 4'b0110;
  localparam logic [3:0] SF = 4'b1001;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    selBus = SF;
  logic          chkReq = 1'b0;
  logic [AW-1:0] chkAddr = '0;
  logic          busReq = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          chkValid, busReady, busValid, romReq, alertInv, alertRev;
  logic [DW-1:0] chkData, busData, romData;
  logic [AW-1:0] romAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  rom_owner_mux #(.AddrWidth(AW), .DataWidth(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .selBus_i(selBus),
    .chkReq_i(chkReq), .chkAddr_i(chkAddr), .chkValid_o(chkValid), .chkData_o(chkData),
    .busReq_i(busReq), .busAddr_i(busAddr), .busReady_o(busReady),
    .busValid_o(busValid), .busData_o(busData),
    .romReq_o(romReq), .romAddr_o(romAddr), .romData_i(romData),
    .alertInvalid_o(alertInv), .alertRevert_o(alertRev)
  );

  function automatic logic [DW-1:0] romWord(input logic [AW-1:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'd3};
  endfunction

  // ROM model: one-cycle read latency.
  always_ff @(posedge clk) if (romReq) romData <= romWord(romAddr);

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; selBus = SF; busReq = 0; chkReq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  typedef struct packed {
    logic [3:0]    sel;
    logic          bReq;
    logic [AW-1:0] bAddr;
    logic          cReq;
    logic [AW-1:0] cAddr;
    logic          expReady;
    logic          expRomReq;
    logic [AW-1:0] expRomAddr;
    logic          expBusV;
    logic          expChkV;
    logic [AW-1:0] expDataAddr;
  } vec_t;

  // Outputs checked just after each falling edge; registered results refer to the row before.
  localparam vec_t Vecs [8] = '{
    '{SF, 1'b1, 8'd20, 1'b1, 8'd10, 1'b0, 1'b1, 8'd10, 1'b0, 1'b0, 8'd0},
    '{SF, 1'b1, 8'd21, 1'b1, 8'd11, 1'b0, 1'b1, 8'd11, 1'b0, 1'b1, 8'd10},
    '{ST, 1'b0, 8'd22, 1'b1, 8'd12, 1'b0, 1'b1, 8'd12, 1'b0, 1'b1, 8'd11},
    '{ST, 1'b1, 8'd30, 1'b1, 8'd13, 1'b1, 1'b1, 8'd30, 1'b0, 1'b1, 8'd12},
    '{ST, 1'b1, 8'd31, 1'b0, 8'd14, 1'b1, 1'b1, 8'd31, 1'b1, 1'b0, 8'd30},
    '{ST, 1'b1, 8'd32, 1'b1, 8'd15, 1'b1, 1'b1, 8'd32, 1'b1, 1'b0, 8'd31},
    '{ST, 1'b0, 8'd33, 1'b0, 8'd16, 1'b1, 1'b0, 8'd33, 1'b1, 1'b0, 8'd32},
    '{ST, 1'b0, 8'd34, 1'b0, 8'd17, 1'b1, 1'b0, 8'd34, 1'b0, 1'b0, 8'd0}
  };

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(ClkPeriod * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    doReset();
    #1;
    // R1 reset state
    check("R1", "busReady", busReady, 0);
    check("R1", "alerts", {alertInv, alertRev}, 0);
    check("R1", "valids", {busValid, chkValid}, 0);
    check("R9", "busData idle", busData, 0);

    // Table: checker phase, handover (R2), pipelined bus reads (R6), checker reads (R7)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      selBus = Vecs[i].sel; busReq = Vecs[i].bReq; busAddr = Vecs[i].bAddr;
      chkReq = Vecs[i].cReq; chkAddr = Vecs[i].cAddr;
      #1;
      check("R2", $sformatf("row%0d busReady", i), busReady, Vecs[i].expReady);
      check("R1", $sformatf("row%0d romReq", i), romReq, Vecs[i].expRomReq);
      check("R2", $sformatf("row%0d romAddr", i), romAddr, Vecs[i].expRomAddr);
      check("R6", $sformatf("row%0d busValid", i), busValid, Vecs[i].expBusV);
      check("R6", $sformatf("row%0d busData", i), busData,
            Vecs[i].expBusV ? romWord(Vecs[i].expDataAddr) : '0);
      check("R7", $sformatf("row%0d chkValid", i), chkValid, Vecs[i].expChkV);
      check("R7", $sformatf("row%0d chkData", i), chkData,
            Vecs[i].expChkV ? romWord(Vecs[i].expDataAddr) : '0);
      check("R4", $sformatf("row%0d alerts", i), {alertInv, alertRev}, 0);
    end

    // Revert after handover, with a bus read issued on the same edge
    @(negedge clk);
    selBus = SF; busReq = 1; busAddr = 8'd40; chkReq = 1; chkAddr = 8'd50;
    #1;
    check("R3", "romAddr on revert cycle", romAddr, 8'd40);
    check("R5", "revert alert not yet", alertRev, 0);
    @(negedge clk);
    selBus = ST; busAddr = 8'd41; chkAddr = 8'd51;
    #1;
    check("R5", "revert alert raised", alertRev, 1);
    check("R8", "in-flight read dropped", busValid, 0);
    check("R8", "busReady after fault", busReady, 0);
    check("R3", "romAddr stays bus", romAddr, 8'd41);
    check("R3", "romReq no checker access", romReq, 0);
    check("R3", "chkValid after revert", chkValid, 0);
    check("R4", "no invalid alert on revert", alertInv, 0);
    @(negedge clk);
    busReq = 0; chkReq = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R5", "revert alert sticky", alertRev, 1);
    check("R9", "busData zero", busData, 0);

    // Illegal code before handover
    doReset();
    selBus = 4'b0000;
    #1;
    check("R4", "invalid alert not yet", alertInv, 0);
    @(negedge clk);
    selBus = ST; busReq = 1; busAddr = 8'd60;
    #1;
    check("R4", "invalid alert raised", alertInv, 1);
    check("R5", "no revert alert", alertRev, 0);
    @(negedge clk);
    #1;
    check("R8", "busReady gated after handover", busReady, 0);
    check("R8", "romReq gated", romReq, 0);
    repeat (4) @(negedge clk);
    #1;
    check("R4", "invalid alert sticky", alertInv, 1);
    check("R8", "busValid gated", busValid, 0);
    busReq = 0;

    // Illegal code after handover
    doReset();
    selBus = ST;
    @(negedge clk);
    #1;
    check("R2", "handover ready", busReady, 1);
    @(negedge clk);
    selBus = 4'b1111;
    @(negedge clk);
    selBus = ST;
    #1;
    check("R4", "invalid after handover", alertInv, 1);
    check("R5", "no revert on illegal code", alertRev, 0);
    check("R8", "busReady dropped", busReady, 0);

    finishRun();
  end

endmodule